// File: doc/BRIEF.md
# Serial Programmer Bulk Erase Sequencer

This block is the host side of a two-wire serial programming link. When it receives a start pulse, it takes a 16-bit erase option code and a delay count. It then drives a serial clock line and a data line to make the target erase the memory regions that the code selects. The erase option code is split into its two bytes. Each byte goes to one of two erase control registers in the target, through a table write whose payload is that byte repeated twice.

Every frame on the wire is a 4-bit command followed by a 16-bit payload. Both are shifted least significant bit first. The sequence runs in this order:

- three core-instruction frame pairs load a 24-bit table pointer;
- a table write sends the high byte;
- the pointer low byte is reloaded;
- a second table write sends the low byte;
- a no-operation frame follows.

After the no-operation frame the block gives four more serial clocks with data low. The target starts erasing on the fourth falling edge. The block then keeps both lines low for the programmed number of cycles and pulses done.

Top module: `bulk_erase_seq`

## Requirements
- R1: After reset, pgc, pgd, busy and done are all low.
- R2: Each serial bit lasts two clock cycles. pgc is high in the first cycle and low in the second. pgd changes only in the cycle where pgc rises and holds its value across the falling edge. A frame is 20 bits: a 4-bit command and then a 16-bit payload, each sent least significant bit first.
- R3: Frames 0 to 6 load the table pointer and write the high byte of the erase code, in this order:
  - command 0000 with payloads 0E3Ch, 6EF8h, 0E00h, 6EF7h, 0E05h and 6EF6h;
  - command 1100 with payload {code[15:8], code[15:8]}.
- R4: Frames 7 to 13 load the pointer again with 04h as the low byte and write the low byte of the erase code, in this order:
  - command 0000 with payloads 0E3Ch, 6EF8h, 0E00h, 6EF7h, 0E04h and 6EF6h;
  - command 1100 with payload {code[7:0], code[7:0]}.
- R5: Frame 14 is a no-operation: command 0000 with payload 0000h.
- R6: After frame 14 the block sends exactly four more pgc periods with pgd low. The erase starts on the fourth of these falling edges, which is falling edge number 304 of the run.
- R7: From the erase start until done, pgc and pgd stay low. done goes high max(D,1)+1 cycles after the cycle in which the erase starts. D is the erase_delay value captured at start.
- R8: busy is high from the cycle after start is accepted through the cycle in which done is high. done is high for exactly one cycle, and busy is low in the cycle after it.
- R9: A start pulse while busy is ignored. The erase code and the delay are captured only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bulk erase; accepted only when idle |
| erase_code | input | 16 | Erase option code written to the two control registers |
| erase_delay | input | DLY_W | Erase plus hold time in clock cycles |
| pgc | output | 1 | Serial programming clock |
| pgd | output | 1 | Serial programming data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the delay |

## Verification
A wrong frame index or payload selection shows up as a mismatched 20-bit frame. It is visible at the falling edge of the first wrong bit, at most 40 cycles after the fault. A bit counter that is off by one shifts every later frame and changes the count of falling edges, so the erase start lands on the wrong edge. A fault in the delay counter moves the done pulse against the 304th falling edge, or lets pgc toggle during the quiet window.

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      erase_code,
  input  logic [DLY_W-1:0] erase_delay,
  output logic             pgc,
  output logic             pgd,
  output logic             busy,
  output logic             done
);
  localparam int FRAME_BITS = 20;
  localparam int NFRM       = 15;
  localparam int TAIL_CLKS  = 4;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int FW         = $clog2(NFRM);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_TAIL, S_WAIT, S_FIN} st_t;

  st_t              st;
  logic             ph;
  logic [BW-1:0]    bcnt;
  logic [FW-1:0]    fidx;
  logic [15:0]      code_q;
  logic [DLY_W-1:0] dly_q, dcnt;
  logic [15:0]      pay;
  logic [3:0]       cmd;
  logic [19:0]      word;

  always_comb begin
    case (fidx)
      FW'(0), FW'(7):  pay = 16'h0E3C;
      FW'(1), FW'(8):  pay = 16'h6EF8;
      FW'(2), FW'(9):  pay = 16'h0E00;
      FW'(3), FW'(10): pay = 16'h6EF7;
      FW'(4):          pay = 16'h0E05;
      FW'(11):         pay = 16'h0E04;
      FW'(5), FW'(12): pay = 16'h6EF6;
      FW'(6):          pay = {code_q[15:8], code_q[15:8]};
      FW'(13):         pay = {code_q[7:0], code_q[7:0]};
      default:         pay = 16'h0000;
    endcase
  end

  assign cmd  = (fidx == FW'(6) || fidx == FW'(13)) ? 4'b1100 : 4'b0000;
  assign word = {pay, cmd};
  assign pgc  = (st == S_SHIFT || st == S_TAIL) && !ph;
  assign pgd  = (st == S_SHIFT) && word[bcnt];
  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= 1'b0;
      bcnt   <= '0;
      fidx   <= '0;
      code_q <= '0;
      dly_q  <= '0;
      dcnt   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          code_q <= erase_code;
          dly_q  <= erase_delay;
          st     <= S_SHIFT;
          ph     <= 1'b0;
          bcnt   <= '0;
          fidx   <= '0;
        end
        S_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            if (bcnt == BW'(FRAME_BITS-1)) begin
              bcnt <= '0;
              if (fidx == FW'(NFRM-1)) st <= S_TAIL;
              else fidx <= fidx + 1'b1;
            end else bcnt <= bcnt + 1'b1;
          end
        end
        S_TAIL: begin
          ph <= ~ph;
          if (ph) begin
            if (bcnt == BW'(TAIL_CLKS-1)) begin
              st   <= S_WAIT;
              dcnt <= dly_q;
            end else bcnt <= bcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (dcnt <= DLY_W'(1)) st <= S_FIN;
          else dcnt <= dcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DATA_ON_RISE:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(pgd) |-> $rose(pgc)); // R2
  AST_DATA_HELD_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(pgc) |-> $stable(pgd)); // R2
  AST_FRAME_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) fidx <= FW'(NFRM-1)); // R3
  AST_ERASE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> (!pgd && !pgc)); // R7
  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R8
  AST_START_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> ($stable(code_q) && $stable(dly_q))); // R9
endmodule

// File: tb/bulk_erase_seq_tb.sv
module bulk_erase_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] erase_code = '0;
  logic [DLY_W-1:0] erase_delay = '0;
  logic pgc, pgd, busy, done;
  int checks = 0, errors = 0;

  bulk_erase_seq #(.DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_code(erase_code),
    .erase_delay(erase_delay), .pgc(pgc), .pgd(pgd), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_word(input int f, input logic [15:0] code);
    logic [15:0] p;
    logic [3:0] c;
    c = 4'b0000;
    case (f)
      0, 7:  p = 16'h0E3C;
      1, 8:  p = 16'h6EF8;
      2, 9:  p = 16'h0E00;
      3, 10: p = 16'h6EF7;
      4:     p = 16'h0E05;
      11:    p = 16'h0E04;
      5, 12: p = 16'h6EF6;
      6:     begin p = {code[15:8], code[15:8]}; c = 4'b1100; end
      13:    begin p = {code[7:0], code[7:0]}; c = 4'b1100; end
      default: p = 16'h0000;
    endcase
    return {p, c};
  endfunction

  task automatic run(input logic [15:0] code, input int dly, input bit inject);
    logic [299:0] bits;
    int falls, es, n, limit;
    logic prev_pgc;
    bit got_done, quiet_ok, tail_ok;
    bits = '0; falls = 0; es = -1; got_done = 0; quiet_ok = 1; tail_ok = 1;
    @(negedge clk);
    erase_code = code; erase_delay = DLY_W'(dly); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R8", "busy after start", busy, 1);
    prev_pgc = 1'b0;
    limit = 700 + dly;
    for (n = 0; n < limit && !got_done; n++) begin
      if (n > 0) @(negedge clk);
      if (prev_pgc && !pgc) begin
        falls++;
        if (falls <= 300) bits[falls-1] = pgd;
        else if (pgd !== 1'b0) tail_ok = 0;
        if (falls == 304) es = n;
      end
      if (es >= 0 && n > es && (pgc !== 1'b0 || pgd !== 1'b0)) quiet_ok = 0;
      if (done === 1'b1) begin
        got_done = 1;
        chk(busy === 1'b1, "R8", "busy during done", busy, 1);
        chk(n - es == ((dly < 1 ? 1 : dly) + 1), "R7", "done latency", n - es,
            (dly < 1 ? 1 : dly) + 1);
      end else if (busy !== 1'b1) begin
        chk(0, "R8", "busy dropped early", busy, 1);
        break;
      end
      prev_pgc = pgc;
      if (inject && n == 100) begin
        start = 1'b1; erase_code = ~code; erase_delay = DLY_W'(dly + 5);
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(got_done, "R8", "done seen", got_done, 1);
    chk(falls == 304, "R6", "falling edge count", falls, 304);
    chk(tail_ok, "R6", "tail pgd low", tail_ok, 1);
    chk(quiet_ok, "R7", "lines low during erase", quiet_ok, 1);
    for (int f = 0; f < 15; f++) begin
      logic [19:0] e;
      e = exp_word(f, code);
      chk(bits[f*20 +: 20] === e, f < 7 ? "R3" : (f < 14 ? "R4" : "R5"),
          inject ? "frame (R9 start while busy)" : "frame", bits[f*20 +: 20], e);
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R8", "after done pulse", {busy, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(pgc === 1'b0 && pgd === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R1", "reset outputs", {pgc, pgd, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pgc === 1'b0 && pgd === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R1", "idle outputs", {pgc, pgd, busy, done}, 0);
    run(16'h3F8F, 0, 0);
    run(16'h3F8F, 1, 0);
    run(16'h0000, 3, 0);
    run(16'hFFFF, 2, 0);
    run(16'h0084, 40, 1);
    for (int i = 0; i < 16; i++)
      run(16'($urandom), int'($urandom % 300), (i % 4) == 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule